// File: doc/BRIEF.md
# Rotating Priority Resolver with Nesting

This block is the decision core of an eight-line interrupt controller. Each cycle it looks at the pending request lines, removes the masked ones, and ranks the rest against a priority base that can be rotated. It then compares the best pending line with the best line already in service. An interrupt is presented to the processor only when the new request outranks everything being serviced. The output and the winning line number are combinational functions of the inputs and the registered state.

The processor acknowledges with a one-cycle strobe. In that cycle it samples the winning line, and the block marks that line as in service. An end-of-interrupt command port retires in-service lines, either the highest ranked one or a named one. It can also move the priority base and switch rotation on automatic end-of-interrupt on or off. With automatic end-of-interrupt, an acknowledge leaves the in-service vector unchanged. A special fully nested input stops the primary instance from counting the in-service bit of its cascade line (line 2) as a blocker.

Top module: `prio_resolver`

## Requirements
- R1: After reset the base is 0, no line is in service, rotation on auto end-of-interrupt is off, `irq_o` is 0 and `line_o` is 7.
- R2: The winning pending line is the first set bit of `req_i & ~mask_i`, scanning lines base, base+1, and on up modulo 8. A masked line never wins.
- R3: `irq_o` is 1 only when the winner's rank is strictly smaller than the rank of the best in-service line. When `irq_o` is 0, `line_o` is 7.
- R4: When `sfnm_i` is 1, in-service bit 2 is left out of the in-service rank, so a new request on line 2 can be raised while line 2 is in service.
- R5: An acknowledge while `irq_o` is 1 and `aeoi_i` is 0 sets the in-service bit of `line_o`. An acknowledge while `irq_o` is 0 changes nothing.
- R6: An acknowledge with `aeoi_i` at 1 leaves the in-service vector unchanged. If rotation on auto end-of-interrupt is on, it also sets the base to (`line_o`+1) mod 8.
- R7: Command op 0 clears the highest-ranked in-service bit. Op 1 does the same and also sets the base to that line plus 1, mod 8. Both have no effect when nothing is in service.
- R8: Command op 2 clears the in-service bit of `cmd_line_i`. Op 3 does the same and also sets the base to (`cmd_line_i`+1) mod 8.
- R9: Command op 4 sets the base to (`cmd_line_i`+1) mod 8 and leaves the in-service bits alone.
- R10: Command op 5 turns rotation on auto end-of-interrupt off, op 6 turns it on, and op 7 has no effect.
- R11: When `ack_i` and `cmd_valid_i` are high in the same cycle, the acknowledge is carried out and the command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Pending request vector |
| mask_i | input | 8 | Mask vector, 1 blocks a line |
| ack_i | input | 1 | Acknowledge strobe |
| cmd_valid_i | input | 1 | End-of-interrupt command strobe |
| cmd_op_i | input | 3 | Command code (see R7 to R10) |
| cmd_line_i | input | 3 | Line operand of the command |
| aeoi_i | input | 1 | Automatic end-of-interrupt enable |
| sfnm_i | input | 1 | Special fully nested enable |
| irq_o | output | 1 | Interrupt to the processor |
| line_o | output | 3 | Winning line, 7 when none qualifies |
| isr_o | output | 8 | In-service vector |
| base_o | output | 3 | Current priority base |

## Verification
The hardest situation to reach is a deep nest under a rotated base. In that state several in-service bits sit at different ranks relative to a base that has moved, so both priority encoders and the comparison between them are exercised at once. The stimulus builds this state step by step. It sets the base with op 4, acknowledges ever higher-ranked requests so the lines stack up in service, and then retires them with the rotating commands. A long pseudo-random phase then mixes acknowledges, commands and mode changes, and compares every output with a model kept in the bench.

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int LINES   = 8,
  parameter int CASCADE = 2,
  parameter bit PRIMARY = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LINES-1:0]           req_i,
  input  logic [LINES-1:0]           mask_i,
  input  logic                       ack_i,
  input  logic                       cmd_valid_i,
  input  logic [2:0]                 cmd_op_i,
  input  logic [$clog2(LINES)-1:0]   cmd_line_i,
  input  logic                       aeoi_i,
  input  logic                       sfnm_i,
  output logic                       irq_o,
  output logic [$clog2(LINES)-1:0]   line_o,
  output logic [LINES-1:0]           isr_o,
  output logic [$clog2(LINES)-1:0]   base_o
);
  localparam int IW = $clog2(LINES);
  localparam logic [IW:0]   NONE  = (IW+1)'(LINES);
  localparam logic [IW-1:0] SPUR  = IW'(LINES-1);
  localparam logic [2:0] OP_EOI = 3'd0, OP_REOI = 3'd1, OP_SEOI = 3'd2,
                         OP_RSEOI = 3'd3, OP_SETB = 3'd4, OP_ROFF = 3'd5,
                         OP_RON = 3'd6;

  logic [LINES-1:0] isr_q;
  logic [IW-1:0]    base_q;
  logic             rot_q;

  function automatic logic [IW:0] rank(input logic [LINES-1:0] v, input logic [IW-1:0] b);
    logic [IW-1:0] idx;
    rank = NONE;
    for (int p = LINES-1; p >= 0; p--) begin
      idx = IW'(p) + b;
      if (v[idx]) rank = (IW+1)'(p);
    end
  endfunction

  logic [LINES-1:0] pend, isr_cmp;
  logic [IW:0]      best_pend, best_isr, top_isr;
  logic [IW-1:0]    win_line, top_line;

  assign pend      = req_i & ~mask_i;
  assign isr_cmp   = (PRIMARY && sfnm_i) ? (isr_q & ~(LINES'(1) << CASCADE)) : isr_q;
  assign best_pend = rank(pend, base_q);
  assign best_isr  = rank(isr_cmp, base_q);
  assign top_isr   = rank(isr_q, base_q);
  assign win_line  = IW'(best_pend) + base_q;
  assign top_line  = IW'(top_isr) + base_q;

  assign irq_o  = best_pend < best_isr;
  assign line_o = irq_o ? win_line : SPUR;
  assign isr_o  = isr_q;
  assign base_o = base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
      rot_q  <= 1'b0;
    end else if (ack_i) begin
      if (irq_o) begin
        if (!aeoi_i) isr_q[win_line] <= 1'b1;
        else if (rot_q) base_q <= win_line + 1'b1;
      end
    end else if (cmd_valid_i) begin
      case (cmd_op_i)
        OP_EOI, OP_REOI: if (top_isr != NONE) begin
          isr_q[top_line] <= 1'b0;
          if (cmd_op_i == OP_REOI) base_q <= top_line + 1'b1;
        end
        OP_SEOI:  isr_q[cmd_line_i] <= 1'b0;
        OP_RSEOI: begin
          isr_q[cmd_line_i] <= 1'b0;
          base_q <= cmd_line_i + 1'b1;
        end
        OP_SETB:  base_q <= cmd_line_i + 1'b1;
        OP_ROFF:  rot_q <= 1'b0;
        OP_RON:   rot_q <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

module prio_resolver_chk #(
  parameter int LINES = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ack_i,
  input logic                     cmd_valid_i,
  input logic [2:0]               cmd_op_i,
  input logic [$clog2(LINES)-1:0] cmd_line_i,
  input logic                     aeoi_i,
  input logic                     sfnm_i,
  input logic                     irq_o,
  input logic [$clog2(LINES)-1:0] line_o,
  input logic [LINES-1:0]         isr_o,
  input logic [$clog2(LINES)-1:0] base_o
);
  localparam int IW = $clog2(LINES);

  assert_spurious_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> line_o == IW'(LINES-1));

  assert_not_in_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !sfnm_i |-> !isr_o[line_o]);

  assert_ack_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && irq_o && !aeoi_i |=> isr_o[$past(line_o)]);

  assert_aeoi_keeps_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && aeoi_i |=> isr_o == $past(isr_o));

  assert_eoi_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && !ack_i && cmd_op_i <= 3'd1 && isr_o == '0 |=> isr_o == '0 && $stable(base_o));

  assert_specific_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && !ack_i && cmd_op_i == 3'd2 |=> !isr_o[$past(cmd_line_i)] && $stable(base_o));

  assert_set_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && !ack_i && cmd_op_i == 3'd4 |=> base_o == IW'($past(cmd_line_i) + 1'b1) && $stable(isr_o));
endmodule

bind prio_resolver prio_resolver_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .cmd_valid_i(cmd_valid_i),
  .cmd_op_i(cmd_op_i), .cmd_line_i(cmd_line_i), .aeoi_i(aeoi_i), .sfnm_i(sfnm_i),
  .irq_o(irq_o), .line_o(line_o), .isr_o(isr_o), .base_o(base_o)
);

// File: tb/tb_prio_resolver.sv
module tb_prio_resolver;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] req_i = '0, mask_i = '0;
  logic ack_i = 1'b0, cmd_valid_i = 1'b0, aeoi_i = 1'b0, sfnm_i = 1'b0;
  logic [2:0] cmd_op_i = '0, cmd_line_i = '0;
  logic irq_o;
  logic [2:0] line_o, base_o;
  logic [7:0] isr_o;

  int checks = 0, errors = 0;
  logic [7:0] m_isr = '0;
  logic [2:0] m_base = '0;
  logic m_rot = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_resolver dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i), .ack_i(ack_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_line_i(cmd_line_i),
    .aeoi_i(aeoi_i), .sfnm_i(sfnm_i), .irq_o(irq_o), .line_o(line_o),
    .isr_o(isr_o), .base_o(base_o)
  );

  function automatic int best(logic [7:0] v, logic [2:0] b);
    for (int p = 0; p < 8; p++) if (v[3'(p) + b]) return p;
    return 8;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [7:0] r, logic [7:0] m, logic a, logic cv,
                      logic [2:0] op, logic [2:0] ln, logic ae, logic sf);
    int bp, cur, top;
    logic e_irq;
    logic [2:0] e_line, top_line;
    @(negedge clk);
    req_i = r; mask_i = m; ack_i = a; cmd_valid_i = cv;
    cmd_op_i = op; cmd_line_i = ln; aeoi_i = ae; sfnm_i = sf;
    #1;
    bp  = best(r & ~m, m_base);
    cur = best(sf ? (m_isr & 8'hFB) : m_isr, m_base);
    e_irq  = bp < cur;
    e_line = e_irq ? 3'(bp) + m_base : 3'd7;
    chk(tag, "irq", int'(irq_o), int'(e_irq));
    chk(tag, "line", int'(line_o), int'(e_line));
    chk(tag, "isr", int'(isr_o), int'(m_isr));
    chk(tag, "base", int'(base_o), int'(m_base));
    @(posedge clk);
    if (a) begin
      if (e_irq) begin
        if (!ae) m_isr[e_line] = 1'b1;
        else if (m_rot) m_base = e_line + 3'd1;
      end
    end else if (cv) begin
      top = best(m_isr, m_base);
      top_line = 3'(top) + m_base;
      case (op)
        3'd0, 3'd1: if (top < 8) begin
          m_isr[top_line] = 1'b0;
          if (op == 3'd1) m_base = top_line + 3'd1;
        end
        3'd2: m_isr[ln] = 1'b0;
        3'd3: begin m_isr[ln] = 1'b0; m_base = ln + 3'd1; end
        3'd4: m_base = ln + 3'd1;
        3'd5: m_rot = 1'b0;
        3'd6: m_rot = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step("R1", 8'h00, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0);

    for (int b = 0; b < 8; b++) begin
      step("R9", 8'h00, 8'h00, 0, 1, 3'd4, 3'(b + 7), 0, 0);
      for (int r = 0; r < 256; r++)
        step("R2", 8'(r), 8'(r * 37 + b), 0, 0, 3'd0, 3'd0, 0, 0);
    end

    step("R9", 8'h00, 8'h00, 0, 1, 3'd4, 3'd3, 0, 0);
    step("R5", 8'h01, 8'h00, 1, 0, 3'd0, 3'd0, 0, 0);
    step("R5", 8'h80, 8'h00, 1, 0, 3'd0, 3'd0, 0, 0);
    step("R5", 8'h10, 8'h00, 1, 0, 3'd0, 3'd0, 0, 0);
    step("R3", 8'h81, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0);
    step("R5", 8'h00, 8'h00, 1, 0, 3'd0, 3'd0, 0, 0);
    step("R7", 8'h81, 8'h00, 0, 1, 3'd1, 3'd0, 0, 0);
    step("R7", 8'h81, 8'h00, 0, 1, 3'd0, 3'd0, 0, 0);
    step("R8", 8'h00, 8'h00, 0, 1, 3'd3, 3'd0, 0, 0);
    step("R7", 8'h00, 8'h00, 0, 1, 3'd0, 3'd0, 0, 0);
    step("R7", 8'h00, 8'h00, 0, 1, 3'd1, 3'd0, 0, 0);

    step("R9", 8'h00, 8'h00, 0, 1, 3'd4, 3'd7, 0, 0);
    step("R4", 8'h04, 8'h00, 1, 0, 3'd0, 3'd0, 0, 0);
    step("R4", 8'h04, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0);
    step("R4", 8'h04, 8'h00, 0, 0, 3'd0, 3'd0, 0, 1);
    step("R8", 8'h00, 8'h00, 0, 1, 3'd2, 3'd2, 0, 0);

    step("R10", 8'h00, 8'h00, 0, 1, 3'd6, 3'd0, 0, 0);
    step("R6", 8'h20, 8'h00, 1, 0, 3'd0, 3'd0, 1, 0);
    step("R6", 8'h20, 8'h00, 0, 0, 3'd0, 3'd0, 1, 0);
    step("R10", 8'h00, 8'h00, 0, 1, 3'd7, 3'd5, 0, 0);
    step("R10", 8'h00, 8'h00, 0, 1, 3'd5, 3'd0, 0, 0);
    step("R6", 8'h02, 8'h00, 1, 0, 3'd0, 3'd0, 1, 0);
    step("R6", 8'h02, 8'h00, 0, 0, 3'd0, 3'd0, 1, 0);
    step("R11", 8'h08, 8'h00, 1, 1, 3'd4, 3'd5, 0, 0);
    step("R11", 8'h00, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0);

    for (int i = 0; i < 6000; i++) begin
      logic [15:0] x;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      x = lfsr * 16'd40503 + 16'(i);
      step("R3", x[7:0], x[15:8] & {x[3:0], x[7:4]}, x[9] & x[2], x[11] & x[5],
           x[14:12], x[7:5], x[1] & x[10], x[0] & x[15]);
    end
    finish_run();
  end
endmodule